// File: doc/BRIEF.md
# SAR ADC conversion and readout sequencer

This block runs one conversion-and-readout frame on a successive-approximation converter that has a serial output. A single-cycle start strobe begins a frame. The block then drives the convert line, the select line and the serial clock in the order that the chosen wiring needs. It shifts in the serial result and presents each finished word on a parallel output with a one-cycle valid strobe.

Three wirings are supported, chosen by `wire_mode`:
- 0 or 3: a separate convert line with an active-low select.
- 1: the convert line tied to an active-low select, with a quiet phase before the conversion.
- 2: a daisy chain of up to 32 converters, whose shared select is active high and tied to convert. In this mode one frame reads every device in turn.

All waits are counted in clock cycles and set by parameters. With the defaults, at a 4 ns clock, the waits are: quiet 5 cycles; conversion 105 or 80 cycles for 14/16-bit results; conversion 125 or 100 cycles for 18-bit results.

The configuration inputs are sampled while the block is idle and are held for the whole frame.

Top module: `sar_readout_seq`

## Requirements
- R1: After reset, `busy`, `sclk` and `res_valid` are 0, `cnv` is 0 and `csel` is 1 (the separate-convert idle state, mode 0).
- R2: In modes 0 and 3, `cnv` is 1 for the whole frame. `csel` stays 1 for the conversion wait, goes 0 for the readout, and returns to 1 with `cnv` at 0 when the frame ends.
- R3: In mode 1, `cnv` and `csel` carry the same level. It is 1 when idle, 0 for QUIET_CYC cycles after start, 1 for the conversion wait, and 0 during readout.
- R4: In mode 2, `cnv` and `csel` carry the same level. It is 0 when idle and 1 from start through the conversion wait and the readout. One frame reads `chain_last`+1 words. `sclk` is low in the cycle before and the cycle of any change of `csel`.
- R5: The conversion wait is CONV_STD cycles, or CONV_FAST cycles when `turbo_fixed` is 1, for 14/16-bit results. For 18-bit results it is CONV_STD_WIDE or CONV_FAST_WIDE. In mode 2, `turbo_fixed` is ignored. A frame lasts quiet + conversion + 2·CLK_DIV·width·words + 1 cycles.
- R6: `sclk` idles low and toggles every CLK_DIV cycles during readout. Its first rise comes CLK_DIV cycles after readout begins. `adc_sdo` is sampled MSB first at the clock edge where `sclk` rises.
- R7: `width_sel` = 0 selects 14 bits, 1 selects 16 bits, and 2 or 3 selects 18 bits. Results of 14 or 16 bits are unsigned and appear with `res_data[31:16]` = 0. 18-bit results are sign-extended from bit 17 to 32 bits.
- R8: `res_valid` is high for one cycle, raised at the edge that samples the last bit of a word. `res_idx` gives the word's position in arrival order, from 0 to `chain_last`; it is 0 outside mode 2.
- R9: `busy` is high from the cycle after an accepted start until the cycle the frame ends, and every `res_valid` falls inside it.
- R10: A start strobe, or a change of any configuration input, while `busy` is high has no effect on the running frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Frame start strobe |
| wire_mode | input | 2 | Wiring: 0/3 separate, 1 tied, 2 chain |
| turbo_fixed | input | 1 | Converter permanently in fast mode |
| width_sel | input | 2 | Result width: 0 = 14, 1 = 16, 2/3 = 18 |
| chain_last | input | 5 | Number of chained devices minus one |
| adc_sdo | input | 1 | Serial data from the converter |
| cnv | output | 1 | Convert line level |
| csel | output | 1 | Select line level |
| sclk | output | 1 | Serial clock |
| busy | output | 1 | Frame in progress |
| res_data | output | 32 | Result word |
| res_valid | output | 1 | Result word strobe |
| res_idx | output | 5 | Word position within the frame |

## Verification
A phase counter that is off by even one count moves the edges of `cnv` and `csel` by that cycle, so the per-cycle comparison flags the fault within the frame in which it happens. A bit or divider count that drifts shifts the next word's bits, or moves its `res_valid`, and is caught at that word's strobe. A wrongly latched configuration shows up as a wrong frame length or a wrong word count at the end of the frame.

// File: rtl/sar_seq_pkg.sv
// Shared types for the SAR readout sequencer.
// Assumes: mode encoding is fixed by the port contract.
package sar_seq_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_QUIET = 2'd1,
        PH_CONV  = 2'd2,
        PH_READ  = 2'd3
    } phase_t;

    localparam logic [1:0] WM_TIED  = 2'd1;
    localparam logic [1:0] WM_CHAIN = 2'd2;
    localparam int STORE_W = 32;
endpackage

// File: rtl/sar_phase_timer.sv
// Down-counter timing the quiet and conversion phases.
// Assumes: load value is the phase length minus one; zero flags the last cycle.
module sar_phase_timer #(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    output logic             zero
);
    logic [TMR_W-1:0] cnt;

    // Load on phase entry, otherwise count down and hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (load)           cnt <= load_val;
        else if (cnt != '0)      cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/sar_word_shifter.sv
// Serial clock generator and MSB-first deserializer with width formatting.
// Assumes: go is a one-cycle pulse; configuration inputs are stable while running.
module sar_word_shifter
    import sar_seq_pkg::*;
#(
    parameter int CLK_DIV = 2,
    parameter int IDX_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go,
    input  logic [1:0]         wsel,
    input  logic               chain_en,
    input  logic [IDX_W-1:0]   last_idx,
    input  logic               sdi,
    output logic               running,
    output logic               sclk,
    output logic [STORE_W-1:0] word,
    output logic               word_valid,
    output logic [IDX_W-1:0]   word_idx
);
    localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam int SH_W = 18;

    logic [CW-1:0]   dcnt;
    logic [SH_W-1:0] sreg;
    logic [SH_W-1:0] nw;
    logic [4:0]      bitpos;
    logic [4:0]      wlast;
    logic [IDX_W-1:0] idx;
    logic            final_q;
    logic            tick;

    assign tick = running && (dcnt == CW'(CLK_DIV - 1));
    assign nw   = {sreg[SH_W-2:0], sdi};

    // Last bit position of a word for the selected width.
    always_comb begin
        case (wsel)
            2'd0:    wlast = 5'd13;
            2'd1:    wlast = 5'd15;
            default: wlast = 5'd17;
        endcase
    end

    // Divider, clock toggling, bit capture and word emission.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0; dcnt <= '0; sclk <= 1'b0; sreg <= '0;
            bitpos <= '0; idx <= '0; final_q <= 1'b0;
            word <= '0; word_valid <= 1'b0; word_idx <= '0;
        end else begin
            word_valid <= 1'b0;
            if (go) begin
                running <= 1'b1; dcnt <= '0; sclk <= 1'b0;
                bitpos <= '0; idx <= '0; final_q <= 1'b0;
            end else if (running) begin
                dcnt <= tick ? '0 : dcnt + 1'b1;
                if (tick && !sclk) begin
                    sclk <= 1'b1;
                    sreg <= nw;
                    if (bitpos == wlast) begin
                        bitpos     <= '0;
                        word_valid <= 1'b1;
                        word_idx   <= idx;
                        idx        <= idx + 1'b1;
                        case (wsel)
                            2'd0:    word <= {18'd0, nw[13:0]};
                            2'd1:    word <= {16'd0, nw[15:0]};
                            default: word <= {{(STORE_W-SH_W){nw[SH_W-1]}}, nw};
                        endcase
                        if (!chain_en || idx == last_idx) final_q <= 1'b1;
                    end else begin
                        bitpos <= bitpos + 1'b1;
                    end
                end else if (tick && sclk) begin
                    sclk <= 1'b0;
                    if (final_q) running <= 1'b0;
                end
            end
        end
    end

    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> (word_idx <= last_idx)); // R8
    AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !wsel[1]) |-> (word[31:16] == 16'd0)); // R7
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid); // R8
endmodule

// File: rtl/sar_readout_seq.sv
// Conversion and readout sequencer for a serial SAR converter.
// Sequences quiet, conversion and readout phases per wiring mode and
// decodes the convert and select levels from the phase.
// Assumes: QUIET_CYC and all conversion waits are at least 1; MAX_DEV >= 2.
module sar_readout_seq
    import sar_seq_pkg::*;
#(
    parameter int CLK_DIV        = 2,
    parameter int QUIET_CYC      = 5,
    parameter int CONV_STD       = 105,
    parameter int CONV_FAST      = 80,
    parameter int CONV_STD_WIDE  = 125,
    parameter int CONV_FAST_WIDE = 100,
    parameter int MAX_DEV        = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [1:0]   wire_mode,
    input  logic         turbo_fixed,
    input  logic [1:0]   width_sel,
    input  logic [$clog2(MAX_DEV)-1:0] chain_last,
    input  logic         adc_sdo,
    output logic         cnv,
    output logic         csel,
    output logic         sclk,
    output logic         busy,
    output logic [31:0]  res_data,
    output logic         res_valid,
    output logic [$clog2(MAX_DEV)-1:0] res_idx
);
    localparam int IDX_W = $clog2(MAX_DEV);
    localparam int CMAX0 = (CONV_STD > CONV_FAST) ? CONV_STD : CONV_FAST;
    localparam int CMAX1 = (CONV_STD_WIDE > CONV_FAST_WIDE) ? CONV_STD_WIDE : CONV_FAST_WIDE;
    localparam int CMAX2 = (CMAX0 > CMAX1) ? CMAX0 : CMAX1;
    localparam int CMAX  = (CMAX2 > QUIET_CYC) ? CMAX2 : QUIET_CYC;
    localparam int TMR_W = $clog2(CMAX + 1);

    phase_t            ph;
    logic [1:0]        cfg_mode;
    logic [1:0]        cfg_wsel;
    logic              cfg_turbo;
    logic [IDX_W-1:0]  cfg_last;
    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_zero;
    logic              rd_go;
    logic              rd_running;

    function automatic int unsigned conv_len(input logic [1:0] m,
                                             input logic [1:0] ws,
                                             input logic tb);
        logic fast;
        fast = tb && (m != WM_CHAIN);
        if (ws[1]) return fast ? CONV_FAST_WIDE : CONV_STD_WIDE;
        return fast ? CONV_FAST : CONV_STD;
    endfunction

    // Configuration tracks the inputs while idle and freezes during a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_mode <= '0; cfg_wsel <= '0; cfg_turbo <= 1'b0; cfg_last <= '0;
        end else if (ph == PH_IDLE) begin
            cfg_mode <= wire_mode; cfg_wsel <= width_sel;
            cfg_turbo <= turbo_fixed; cfg_last <= chain_last;
        end
    end

    // Phase sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) ph <= PH_IDLE;
        else begin
            case (ph)
                PH_IDLE:  if (start) ph <= (wire_mode == WM_TIED) ? PH_QUIET : PH_CONV;
                PH_QUIET: if (tmr_zero) ph <= PH_CONV;
                PH_CONV:  if (tmr_zero) ph <= PH_READ;
                default:  if (!rd_running) ph <= PH_IDLE;
            endcase
        end
    end

    // Timer load on entry to the quiet or conversion phase.
    always_comb begin
        tmr_load = (ph == PH_IDLE && start) || (ph == PH_QUIET && tmr_zero);
        if (ph == PH_IDLE)
            tmr_val = (wire_mode == WM_TIED) ? TMR_W'(QUIET_CYC - 1)
                    : TMR_W'(conv_len(wire_mode, width_sel, turbo_fixed) - 1);
        else
            tmr_val = TMR_W'(conv_len(cfg_mode, cfg_wsel, cfg_turbo) - 1);
    end

    assign rd_go = (ph == PH_CONV) && tmr_zero;
    assign busy  = (ph != PH_IDLE);

    // Line levels decoded from phase and wiring.
    always_comb begin
        case (cfg_mode)
            WM_TIED: begin
                cnv  = !(ph == PH_QUIET || ph == PH_READ);
                csel = cnv;
            end
            WM_CHAIN: begin
                cnv  = (ph == PH_CONV || ph == PH_READ);
                csel = cnv;
            end
            default: begin
                cnv  = (ph != PH_IDLE);
                csel = (ph != PH_READ);
            end
        endcase
    end

    sar_phase_timer #(.TMR_W(TMR_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
    );

    sar_word_shifter #(.CLK_DIV(CLK_DIV), .IDX_W(IDX_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .go(rd_go), .wsel(cfg_wsel),
        .chain_en(cfg_mode == WM_CHAIN), .last_idx(cfg_last), .sdi(adc_sdo),
        .running(rd_running), .sclk(sclk), .word(res_data),
        .word_valid(res_valid), .word_idx(res_idx)
    );

    AST_SCLK_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> (ph == PH_READ)); // R6
    AST_SEL_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (csel != $past(csel)) |-> (!sclk && !$past(sclk))); // R4
    AST_VALID_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> busy); // R9
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_READ) |=> (ph == PH_READ || ph == PH_IDLE)); // R10
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(cfg_mode) && $stable(cfg_wsel))); // R10
endmodule

// File: tb/tb_sar_readout_seq.sv
module tb_sar_readout_seq;
    localparam int DIV = 2, QC = 5, CS = 105, CF = 80, CSW = 125, CFW = 100;

    logic clk = 0, rst_n = 0, start = 0, turbo = 0, sdo = 0;
    logic [1:0] wmode = 0, wsel = 0;
    logic [4:0] clast = 0;
    logic cnv, csel, sclk, busy, res_valid;
    logic [31:0] res_data;
    logic [4:0] res_idx;

    always #2 clk = ~clk;

    sar_readout_seq #(.CLK_DIV(DIV), .QUIET_CYC(QC), .CONV_STD(CS), .CONV_FAST(CF),
        .CONV_STD_WIDE(CSW), .CONV_FAST_WIDE(CFW), .MAX_DEV(32)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .wire_mode(wmode), .turbo_fixed(turbo),
        .width_sel(wsel), .chain_last(clast), .adc_sdo(sdo), .cnv(cnv), .csel(csel),
        .sclk(sclk), .busy(busy), .res_data(res_data), .res_valid(res_valid), .res_idx(res_idx));

    // Inputs as seen by the design at each rising edge.
    logic s_rst = 0, s_start = 0, s_turbo = 0;
    logic [1:0] s_mode = 0, s_wsel = 0;
    logic [4:0] s_last = 0;
    always @(posedge clk) begin
        s_rst <= rst_n; s_start <= start; s_mode <= wmode;
        s_wsel <= wsel; s_turbo <= turbo; s_last <= clast;
    end

    int n_checks = 0, n_fail = 0, cyc = 0;
    bit m_act = 0;
    int t, m_len, m_Q, m_C, m_W, m_N, f_valid, f_busy;
    logic [1:0] m_mode = 0;
    logic m_bits[0:575];
    logic [31:0] m_words[0:31];
    logic [31:0] adc_words[0:31];
    int seed = 7;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    task automatic begin_frame();
        bit chain, fast;
        m_act = 1; t = 0; f_valid = 0; f_busy = 0;
        m_W = (s_wsel == 0) ? 14 : (s_wsel == 1) ? 16 : 18;
        chain = (s_mode == 2);
        m_N = chain ? int'(s_last) + 1 : 1;
        fast = s_turbo && !chain;
        m_C = (m_W == 18) ? (fast ? CFW : CSW) : (fast ? CF : CS);
        m_Q = (s_mode == 1) ? QC : 0;
        m_len = m_Q + m_C + 2 * DIV * m_W * m_N + 1;
        for (int j = 0; j < 32; j++) m_words[j] = adc_words[j] & ((32'd1 << m_W) - 1);
        for (int k = 0; k < m_W * m_N; k++)
            m_bits[k] = m_words[k / m_W][m_W - 1 - (k % m_W)];
    endtask

    // Reference model: advance, compare every output, drive serial data.
    always @(negedge clk) begin
        bit e_sclk, e_valid, e_cnv, e_csel;
        int r, j, tot;
        string ltag;
        logic [31:0] e_data;
        cyc++;
        if (cyc > 190000) begin
            n_fail++; $display("FAIL watchdog R9 actual=%0d expected=%0d", cyc, 0);
            finish_run();
        end
        if (!s_rst) begin m_act = 0; m_mode = 0; end
        else if (!m_act) begin
            m_mode = s_mode;
            if (s_start) begin_frame();
        end else begin
            t++;
            if (t == m_len) begin
                m_act = 0;
                chk(f_busy == m_len, "R5 frame length", f_busy, m_len);
                chk(f_valid == m_N, "R10 words per frame", f_valid, m_N);
            end
        end
        ltag = !s_rst ? "R1" : (m_mode == 1) ? "R3" : (m_mode == 2) ? "R4" : "R2";
        e_sclk = 0; e_valid = 0; j = 0; r = -1; tot = m_W * m_N;
        if (!m_act) begin
            e_cnv = (m_mode == 1);
            e_csel = (m_mode != 2);
        end else if (t < m_Q) begin
            e_cnv = 0; e_csel = 0;
        end else if (t < m_Q + m_C) begin
            e_cnv = 1; e_csel = 1;
        end else begin
            r = t - m_Q - m_C;
            e_cnv = (m_mode != 1);
            e_csel = (m_mode == 2);
            e_sclk = (r < 2 * DIV * tot) && (((r / DIV) % 2) == 1);
            if (r >= DIV && r < 2 * DIV * tot && ((r - DIV) % (2 * DIV)) == 0
                && ((((r - DIV) / (2 * DIV)) + 1) % m_W) == 0) begin
                e_valid = 1;
                j = ((r - DIV) / (2 * DIV)) / m_W;
            end
        end
        chk(busy == m_act, {ltag == "R1" ? "R1" : "R9", " busy"}, busy, m_act);
        chk(sclk == e_sclk, {ltag == "R1" ? "R1" : "R6", " sclk"}, sclk, e_sclk);
        chk(res_valid == e_valid, {ltag == "R1" ? "R1" : "R8", " valid"}, res_valid, e_valid);
        chk(cnv == e_cnv, {ltag, " cnv"}, cnv, e_cnv);
        chk(csel == e_csel, {ltag, " csel"}, csel, e_csel);
        if (e_valid && res_valid) begin
            e_data = m_words[j];
            if (m_W == 18 && e_data[17]) e_data = e_data | 32'hFFFC0000;
            chk(res_data == e_data, "R7 data", res_data, e_data);
            chk(int'(res_idx) == j, "R8 index", res_idx, j);
        end
        if (m_act) begin
            f_busy += busy;
            f_valid += res_valid;
        end
        if (m_act && r >= -1 && t >= m_Q + m_C - 1) begin
            int k;
            k = (t - m_Q - m_C + 1) / (2 * DIV);
            sdo = (k < tot) ? m_bits[k] : 1'b0;
        end else sdo = 1'b0;
    end

    task automatic frame(input logic [1:0] m, input logic [1:0] ws, input bit tb,
                         input logic [4:0] last, input int pat, input bit noise);
        int w;
        w = (ws == 0) ? 14 : (ws == 1) ? 16 : 18;
        @(negedge clk);
        wmode = m; wsel = ws; turbo = tb; clast = last;
        for (int j = 0; j < 32; j++) begin
            seed = seed * 1103515245 + 12345;
            case (pat)
                0: adc_words[j] = 32'(seed >>> 7) ^ 32'(j * 977);
                1: adc_words[j] = 32'hFFFFFFFF;
                2: adc_words[j] = 32'd1 << (w - 1);
                default: adc_words[j] = (j % 2 == 0) ? 32'd0 : 32'h15555;
            endcase
        end
        start = 1;
        @(negedge clk);
        start = 0;
        if (noise) begin
            repeat (40) @(negedge clk);
            start = 1; wmode = m ^ 2'd1; wsel = 2'd0; turbo = ~tb; clast = 5'd7;
            @(negedge clk);
            start = 0;
        end
        while (busy) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk(busy == 0 && sclk == 0 && res_valid == 0, "R1 reset idle", {busy, sclk, res_valid}, 0);
        chk(cnv == 0 && csel == 1, "R1 reset lines", {cnv, csel}, 2'b01);
        rst_n = 1;
        repeat (3) @(negedge clk);
        frame(2'd0, 2'd0, 0, 5'd0, 0, 0);   // R2 14-bit
        frame(2'd0, 2'd1, 1, 5'd0, 1, 0);   // R5 turbo, R7 16-bit max
        frame(2'd3, 2'd2, 0, 5'd0, 2, 0);   // R7 negative 18-bit
        frame(2'd0, 2'd2, 1, 5'd0, 0, 0);   // R5 wide turbo
        frame(2'd1, 2'd1, 0, 5'd0, 0, 0);   // R3 tied
        frame(2'd1, 2'd3, 1, 5'd0, 3, 0);   // R3 tied, width code 3
        frame(2'd2, 2'd1, 1, 5'd2, 0, 0);   // R4 chain, turbo ignored (R5)
        frame(2'd2, 2'd0, 0, 5'd0, 1, 0);   // R4 single device chain
        frame(2'd2, 2'd2, 0, 5'd31, 0, 0);  // R4 full chain, R8 index
        frame(2'd0, 2'd0, 0, 5'd0, 3, 1);   // R10 ignored start and config
        frame(2'd2, 2'd2, 1, 5'd3, 2, 1);   // R10 during chain frame
        finish_run();
    end
endmodule